// File: doc/BRIEF.md
# Node Identity and Successor Registers

This block is the host-facing identity register unit of a node on a token-passing network. It stores three 8-bit values. The first is the node's own identifier. The second is a probe identifier, which the host uses to find out whether some other node is present. The third is the successor identifier, which is the node that the token is passed to next. The host reaches the three registers through a small bus that selects one register with a sub-address. The host can write the own and probe identifiers. The successor identifier can only be read by the host, and the network sequencer loads it.

The block produces two control signals for the node core. The core stays asleep while the own identifier is zero. It is allowed to join the ring only when it is awake and the host's transmit-enable configuration bit is also set. Every load of the successor identifier sets a sticky change flag, and a host read of that register clears the flag. The block also watches the stream of token destinations seen on the wire. When a destination matches the non-zero probe identifier, it sets a sticky probe-hit bit. This detection keeps working while transmit is disabled, because the receive side stays active. Token passing itself, reconfiguration and frame handling are outside this block.

Top module: `node_map_regs`

## Requirements
- R1: After reset (`rst_n` low, synchronous), all three identifiers read 0x00, and `core_awake`, `tx_join`, `next_irq` and `probe_hit` are all low.
- R2: Sub-address 0 reads and writes the probe identifier, and sub-address 1 reads and writes the own identifier. Sub-address 3 reads 0x00, and a write to it changes no register.
- R3: Sub-address 2 reads the successor identifier. A host write to sub-address 2 leaves the successor identifier unchanged.
- R4: `core_awake` is high exactly when the stored own identifier is non-zero. It follows a write on the clock edge that performs the write.
- R5: `tx_join` is high only when `core_awake` is high and `tx_cfg_en` is high. It follows `tx_cfg_en` combinationally.
- R6: A `seq_upd` pulse loads `seq_next_id` into the successor identifier and sets `next_irq` on the next edge. This happens even when the loaded value equals the old one.
- R7: A host read (`host_rd`) of sub-address 2 clears `next_irq` on the next edge. If a `seq_upd` occurs in the same cycle, `next_irq` stays set.
- R8: `probe_hit` is set when `obs_valid` is high, `obs_dest` equals the probe identifier, and the probe identifier is non-zero. This holds whatever the value of `tx_cfg_en`. A probe identifier of 0x00 never sets it.
- R9: A destination that matches the probe identifier does not set `probe_hit` while the probe identifier equals the current successor identifier, because the node's own token passes make such a match meaningless.
- R10: `probe_hit` stays set until the host writes sub-address 0, and that write clears it. If a write and a match happen in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 2 | Register sub-address (0 probe, 1 own, 2 successor, 3 unused) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (clears change flag on sub-address 2) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected register (combinational) |
| tx_cfg_en | input | 1 | Transmit-enable configuration bit |
| seq_upd | input | 1 | Sequencer successor-update strobe |
| seq_next_id | input | 8 | New successor identifier |
| obs_valid | input | 1 | Observed token destination is valid |
| obs_dest | input | 8 | Observed token destination identifier |
| core_awake | output | 1 | Own identifier is non-zero, core may run |
| tx_join | output | 1 | Core may join the ring |
| next_irq | output | 1 | Successor changed since last read |
| probe_hit | output | 1 | A node with the probe identifier was seen |

## Verification
The bench targets the same-cycle collisions. An update that lands with a successor read must keep the flag, and a design that lets the read win would lose a change notice. A probe write that lands with a matching destination must clear the bit, and the opposite priority would report a stale hit. It also reloads an identical successor value, where a design that compares values would not raise the flag. It probes with identifier zero and with the current successor identifier, and a design without those guards would report false hits. Writes to the read-only and unused sub-addresses are read back to catch a decode that aliases them onto a live register.

// File: rtl/nmr_pkg.sv
// Package: shared sub-address encoding for the identity register unit.
// Assumes a 2-bit sub-address; the codes are fixed by the host software map.
package nmr_pkg;
    typedef enum logic [1:0] {
        SUB_PROBE = 2'd0,
        SUB_OWN   = 2'd1,
        SUB_SUCC  = 2'd2,
        SUB_NONE  = 2'd3
    } nmr_sub_e;
endpackage

// File: rtl/nmr_id_regs.sv
// Own and probe identifier storage.
// Assumes write strobes are already decoded and mutually exclusive.
module nmr_id_regs #(
    parameter int unsigned ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_own,
    input  logic            wr_probe,
    input  logic [ID_W-1:0] wdata,
    output logic [ID_W-1:0] own_q,
    output logic [ID_W-1:0] probe_q
);
    // Own identifier register, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      own_q <= '0;
        else if (wr_own) own_q <= wdata;
    end

    // Probe identifier register, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        probe_q <= '0;
        else if (wr_probe) probe_q <= wdata;
    end
endmodule

// File: rtl/nmr_succ.sv
// Successor identifier and its sticky change flag.
// Assumes the update strobe is one cycle per load; an update outranks a clearing read.
module nmr_succ #(
    parameter int unsigned ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic [ID_W-1:0] upd_id,
    input  logic            rd_clr,
    output logic [ID_W-1:0] succ_q,
    output logic            chg_q
);
    // Successor value, loaded only by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)   succ_q <= '0;
        else if (upd) succ_q <= upd_id;
    end

    // Change flag: set on every load, cleared by a read unless a load coincides.
    always_ff @(posedge clk) begin
        if (!rst_n)      chg_q <= 1'b0;
        else if (upd)    chg_q <= 1'b1;
        else if (rd_clr) chg_q <= 1'b0;
    end
endmodule

// File: rtl/nmr_probe.sv
// Probe-hit detector over the observed token-destination stream.
// Assumes compare values are the registered identifiers of the current cycle.
module nmr_probe #(
    parameter int unsigned ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] probe_id,
    input  logic [ID_W-1:0] succ_id,
    input  logic            wr_probe,
    input  logic            obs_valid,
    input  logic [ID_W-1:0] obs_dest,
    output logic            hit_q
);
    logic match;

    // Qualified match: non-zero probe, not the own successor, equal destination.
    always_comb begin
        match = obs_valid && (probe_id != '0) && (probe_id != succ_id)
                && (obs_dest == probe_id);
    end

    // Sticky hit bit; a probe write clears it and wins over a match.
    always_ff @(posedge clk) begin
        if (!rst_n)        hit_q <= 1'b0;
        else if (wr_probe) hit_q <= 1'b0;
        else if (match)    hit_q <= 1'b1;
    end
endmodule

// File: rtl/node_map_regs.sv
// Top: host-addressed identity registers with wake/join gating,
// successor-change flag and probe detection.
// Assumes one host access per cycle; read data is combinational on host_sel.
module node_map_regs #(
    parameter int unsigned ID_W  = 8,
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] host_sel,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [ID_W-1:0]  host_wdata,
    output logic [ID_W-1:0]  host_rdata,
    input  logic             tx_cfg_en,
    input  logic             seq_upd,
    input  logic [ID_W-1:0]  seq_next_id,
    input  logic             obs_valid,
    input  logic [ID_W-1:0]  obs_dest,
    output logic             core_awake,
    output logic             tx_join,
    output logic             next_irq,
    output logic             probe_hit
);
    import nmr_pkg::*;

    nmr_sub_e        sub;
    logic            wr_own, wr_probe, rd_succ;
    logic [ID_W-1:0] own_q, probe_q, succ_q;

    // Sub-address decode into per-register strobes.
    always_comb begin
        sub      = nmr_sub_e'(host_sel[1:0]);
        wr_own   = host_wr && (sub == SUB_OWN);
        wr_probe = host_wr && (sub == SUB_PROBE);
        rd_succ  = host_rd && (sub == SUB_SUCC);
    end

    nmr_id_regs #(.ID_W(ID_W)) ids_i (
        .clk(clk), .rst_n(rst_n), .wr_own(wr_own), .wr_probe(wr_probe),
        .wdata(host_wdata), .own_q(own_q), .probe_q(probe_q)
    );

    nmr_succ #(.ID_W(ID_W)) succ_i (
        .clk(clk), .rst_n(rst_n), .upd(seq_upd), .upd_id(seq_next_id),
        .rd_clr(rd_succ), .succ_q(succ_q), .chg_q(next_irq)
    );

    nmr_probe #(.ID_W(ID_W)) probe_i (
        .clk(clk), .rst_n(rst_n), .probe_id(probe_q), .succ_id(succ_q),
        .wr_probe(wr_probe), .obs_valid(obs_valid), .obs_dest(obs_dest),
        .hit_q(probe_hit)
    );

    // Read-data multiplexer; the unused code returns zero.
    always_comb begin
        unique case (sub)
            SUB_PROBE: host_rdata = probe_q;
            SUB_OWN:   host_rdata = own_q;
            SUB_SUCC:  host_rdata = succ_q;
            default:   host_rdata = '0;
        endcase
    end

    // Wake and join gating for the node core.
    always_comb begin
        core_awake = (own_q != '0);
        tx_join    = core_awake && tx_cfg_en;
    end
endmodule

// File: rtl/nmr_checker.sv
// Property checker for node_map_regs, attached by bind below.
module nmr_checker #(
    parameter int unsigned ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      host_sel,
    input logic            host_wr,
    input logic            host_rd,
    input logic [ID_W-1:0] host_wdata,
    input logic            tx_cfg_en,
    input logic            seq_upd,
    input logic [ID_W-1:0] succ_q,
    input logic [ID_W-1:0] probe_q,
    input logic            core_awake,
    input logic            tx_join,
    input logic            next_irq,
    input logic            probe_hit
);
    AST_SUCC_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_upd |=> $stable(succ_q)); // R3
    AST_WAKE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd1 && host_wdata != '0) |=> core_awake); // R4
    AST_JOIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_join |-> (core_awake && tx_cfg_en)); // R5
    AST_FLAG_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_upd |=> next_irq); // R6
    AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == 2'd2 && !seq_upd) |=> !next_irq); // R7
    AST_ZERO_PROBE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_q == '0) |-> !probe_hit); // R8
    AST_PROBE_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd0) |=> !probe_hit); // R10
endmodule

bind node_map_regs nmr_checker #(.ID_W(ID_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel[1:0]), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .tx_cfg_en(tx_cfg_en),
    .seq_upd(seq_upd), .succ_q(succ_q), .probe_q(probe_q),
    .core_awake(core_awake), .tx_join(tx_join), .next_irq(next_irq),
    .probe_hit(probe_hit)
);

// File: tb/node_map_regs_tb.sv
`timescale 1ns/100ps
module node_map_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       tx_cfg_en = 1'b0, seq_upd = 1'b0, obs_valid = 1'b0;
    logic [7:0] seq_next_id = '0, obs_dest = '0;
    logic       core_awake, tx_join, next_irq, probe_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state
    logic [7:0] m_own = '0, m_probe = '0, m_succ = '0;
    logic       m_irq = 1'b0, m_hit = 1'b0;

    always #2.5 clk = ~clk;

    node_map_regs dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_cfg_en(tx_cfg_en), .seq_upd(seq_upd), .seq_next_id(seq_next_id),
        .obs_valid(obs_valid), .obs_dest(obs_dest), .core_awake(core_awake),
        .tx_join(tx_join), .next_irq(next_irq), .probe_hit(probe_hit)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0:    return m_probe;
            2'd1:    return m_own;
            2'd2:    return m_succ;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_match(input logic ov, input logic [7:0] od);
        return ov && (m_probe != 0) && (m_probe != m_succ) && (od == m_probe);
    endfunction

    // One bus cycle: drive, check read data, clock, update model, check outputs.
    task automatic cyc(input logic [1:0] s, input logic wr, input logic rd,
                       input logic [7:0] wd, input logic upd, input logic [7:0] nid,
                       input logic ov, input logic [7:0] od, input logic tx);
        logic [7:0] n_own, n_probe, n_succ;
        logic       n_irq, n_hit;
        @(negedge clk);
        host_sel = s; host_wr = wr; host_rd = rd; host_wdata = wd;
        seq_upd = upd; seq_next_id = nid; obs_valid = ov; obs_dest = od;
        tx_cfg_en = tx;
        #1;
        if (rd) check(host_rdata, exp_read(s), (s == 2'd2) ? "R3" : "R2");
        n_own   = (wr && s == 2'd1) ? wd : m_own;
        n_probe = (wr && s == 2'd0) ? wd : m_probe;
        n_succ  = upd ? nid : m_succ;
        n_irq   = upd ? 1'b1 : ((rd && s == 2'd2) ? 1'b0 : m_irq);
        n_hit   = (wr && s == 2'd0) ? 1'b0 : (exp_match(ov, od) ? 1'b1 : m_hit);
        @(posedge clk);
        #1;
        m_own = n_own; m_probe = n_probe; m_succ = n_succ; m_irq = n_irq; m_hit = n_hit;
        check({7'd0, core_awake}, {7'd0, m_own != 0}, "R4");
        check({7'd0, tx_join}, {7'd0, (m_own != 0) && tx}, "R5");
        check({7'd0, next_irq}, {7'd0, m_irq}, "R6/R7");
        check({7'd0, probe_hit}, {7'd0, m_hit}, "R8/R9/R10");
    endtask

    initial begin
        int cnt = 0;
        while (!done && cnt < 200000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset values
        #1;
        check({4'd0, core_awake, tx_join, next_irq, probe_hit}, 8'h00, "R1");
        for (int s = 0; s < 3; s++) begin
            host_sel = 2'(s); #1;
            check(host_rdata, 8'h00, "R1");
        end
        // R4/R5: asleep while own ID zero, then wake and join gating
        cyc(2'd1, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        cyc(2'd1, 1, 0, 8'h05, 0, 0, 0, 0, 0);
        cyc(2'd1, 0, 1, 8'h00, 0, 0, 0, 0, 1);
        cyc(2'd1, 0, 0, 8'h00, 0, 0, 0, 0, 0);
        // R3: write to successor ignored
        cyc(2'd2, 1, 0, 8'h77, 0, 0, 0, 0, 0);
        cyc(2'd2, 0, 1, 8'h00, 0, 0, 0, 0, 0);
        // R2: unused sub-address reads zero, write lands nowhere
        cyc(2'd3, 1, 0, 8'h33, 0, 0, 0, 0, 0);
        cyc(2'd3, 0, 1, 8'h00, 0, 0, 0, 0, 0);
        cyc(2'd1, 0, 1, 8'h00, 0, 0, 0, 0, 0);
        cyc(2'd0, 0, 1, 8'h00, 0, 0, 0, 0, 0);
        // R6/R7: load, read-clear, same-value reload, collision
        cyc(2'd0, 0, 0, 8'h00, 1, 8'h09, 0, 0, 0);
        cyc(2'd2, 0, 1, 8'h00, 0, 0, 0, 0, 0);
        cyc(2'd0, 0, 0, 8'h00, 1, 8'h09, 0, 0, 0);
        cyc(2'd2, 0, 1, 8'h00, 1, 8'h0A, 0, 0, 0);
        check({7'd0, next_irq}, 8'h01, "R7");
        cyc(2'd2, 0, 1, 8'h00, 0, 0, 0, 0, 0);
        // R8: zero probe never hits; match with transmit disabled
        cyc(2'd0, 0, 0, 8'h00, 0, 0, 1, 8'h00, 0);
        cyc(2'd0, 1, 0, 8'h03, 0, 0, 0, 0, 0);
        cyc(2'd0, 0, 0, 8'h00, 0, 0, 1, 8'h03, 0);
        check({7'd0, probe_hit}, 8'h01, "R8");
        cyc(2'd0, 0, 0, 8'h00, 0, 0, 1, 8'h04, 0);
        // R10: write clears; write beats same-cycle match
        cyc(2'd0, 1, 0, 8'h03, 0, 0, 1, 8'h03, 0);
        check({7'd0, probe_hit}, 8'h00, "R10");
        // R9: probe equal to successor does not hit
        cyc(2'd0, 0, 0, 8'h00, 1, 8'h06, 0, 0, 0);
        cyc(2'd0, 1, 0, 8'h06, 0, 0, 0, 0, 0);
        cyc(2'd0, 0, 0, 8'h00, 0, 0, 1, 8'h06, 0);
        check({7'd0, probe_hit}, 8'h00, "R9");
        // Random mix with small ID space to force matches
        for (int i = 0; i < 4000; i++) begin
            cyc(2'($urandom % 4), ($urandom % 3) == 0, ($urandom % 2) == 1,
                8'($urandom % 6), ($urandom % 5) == 0, 8'($urandom % 6),
                ($urandom % 2) == 1, 8'($urandom % 6), ($urandom % 2) == 1);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule